// File: doc/BRIEF.md
# Dual-Scan LCD Refresh Sequencer

This block generates the display-memory refresh addresses and the panel timing strobes for a dot-matrix LCD that is driven as two halves scanned at the same time. A character-period tick comes in from the dot-clock divider. The block runs a horizontal position counter, a line counter and a raster counter. Within every character period it first presents the memory address for the upper half of the panel and then the address for the lower half. The external display RAM or character generator and the shift-out datapath consume these addresses. The CPU register interface is outside the block.

Each line runs for the programmed number of visible characters plus a fixed eight-character blanking tail. During the tail, the line latch, segment-driver chip-enable clock and busy strobes are produced, while the address counter keeps stepping. In graphic mode every panel line fetches a fresh run of memory. In character mode one row of character codes is fetched for several consecutive lines while the raster output steps through the font rows. A frame strobe marks the first line. An AC-inversion output flips once per frame. The display start address is sampled only at frame boundaries, so scrolling does not tear the picture.

Configuration values (`hnM1`, `vrM1`, `vpM1`, `graphicMode`) are expected to be static outside reset.

Top module: `lcd_refresh_seq`

## Requirements
- R1: `charClk` toggles on each cycle with `chTick` high. While `charClk` is 0, `memAddr` is the upper-half address. While it is 1, `memAddr` is that upper address plus a half offset. The half offset is Vr×HN in graphic mode and (Vr/Vp)×HN in character mode, where HN = `hnM1`+1, Vr = `vrM1`+1 and Vp = `vpM1`+1.
- R2: A new character period begins when `chTick` is high while `charClk` is 1, which is the falling edge of `charClk`. The horizontal position then advances by one. With `chTick` low, `charClk` and `memAddr` hold.
- R3: A line lasts HN+8 character periods, with positions 0 to HN+7. The upper address is the row base plus the position, and it keeps incrementing through blanking positions HN to HN+7.
- R4: In graphic mode (`graphicMode`=1), the row base increases by HN at every line end, and `rasterAddr` stays 0.
- R5: In character mode (`graphicMode`=0), `rasterAddr` counts 0 to Vp−1 over consecutive lines. The row base increases by HN only when a line ends with `rasterAddr` = Vp−1.
- R6: `busy` is high exactly at positions HN+1 to HN+7, which is 7 character periods.
- R7: `lineLatch` is high at positions HN and HN+1. `chipEnClk` is high only at position HN+2.
- R8: A frame is Vr lines. `frameStrobe` is high during line 0. `acInvert` toggles at the end of every frame.
- R9: `startAddr` is loaded into the row base only at a frame end or in reset. A change mid-frame does not affect the addresses of the current frame.
- R10: A synchronous active-high `rst` clears `charClk`, the position, the line and the raster to 0, clears `acInvert`, and loads the row base from `startAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chTick | input | 1 | Half-character-period advance pulse |
| startAddr | input | 16 | Display start address |
| hnM1 | input | 7 | Characters per line minus one |
| vrM1 | input | 8 | Lines per half minus one |
| vpM1 | input | 4 | Font rows per character minus one |
| graphicMode | input | 1 | 1 = graphic, 0 = character |
| memAddr | output | 16 | Refresh address, upper then lower half |
| rasterAddr | output | 4 | Font row address |
| charClk | output | 1 | Character clock, 0 = upper phase |
| lineLatch | output | 1 | Line latch strobe |
| chipEnClk | output | 1 | Segment-driver chip-enable clock |
| busy | output | 1 | Blanking window open to CPU access |
| frameStrobe | output | 1 | First line of frame |
| acInvert | output | 1 | Frame-alternating inversion |

## Verification
The busiest cycle is the last character period of the last line. In that one edge the line ends, the raster wraps, the row base reloads from the start address and `acInvert` flips. A start address change can also land in that same frame. The bench provokes this by changing `startAddr` in the middle of a frame. It then judges that the old base is used up to the wrap and that the new base appears exactly at position 0 of the next frame's line 0, together with the inversion toggle and the frame strobe.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int ADDR_W  = 16;
  localparam int HN_W    = 7;
  localparam int VR_W    = 8;
  localparam int VP_W    = 4;
  localparam int BLANK_N = 8;
  localparam int POS_W   = HN_W + 1;

  typedef struct packed {
    logic             phase;
    logic             rowStep;
    logic             frameEnd;
    logic [POS_W-1:0] charPos;
  } seqCtrl_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            chTick,
  input  logic            graphicMode,
  input  logic [HN_W-1:0] hnM1,
  input  logic [VR_W-1:0] vrM1,
  input  logic [VP_W-1:0] vpM1,
  output seqCtrl_t        ctrl,
  output logic [VP_W-1:0] rasterAddr,
  output logic            lineLatch,
  output logic            chipEnClk,
  output logic            busy,
  output logic            frameStrobe,
  output logic            acInvert
);
  localparam int SLOT_W = $clog2(BLANK_N);

  logic             phase;
  logic [POS_W-1:0] charPos;
  logic [VR_W-1:0]  lineCnt;
  logic [VP_W-1:0]  rasterCnt;
  logic [POS_W-1:0] hnCount;
  logic [POS_W-1:0] lastPos;
  logic [POS_W-1:0] slotWide;
  logic [SLOT_W-1:0] slot;
  logic             inBlank;
  logic             charAdv;
  logic             lineEnd;
  logic             frameEnd;
  logic             rowStep;

  assign hnCount  = {1'b0, hnM1} + POS_W'(1);
  assign lastPos  = {1'b0, hnM1} + POS_W'(BLANK_N);
  assign charAdv  = chTick & phase;
  assign lineEnd  = charAdv & (charPos == lastPos);
  assign frameEnd = lineEnd & (lineCnt == vrM1);
  assign rowStep  = lineEnd & ~frameEnd & (graphicMode | (rasterCnt == vpM1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      charPos   <= '0;
      lineCnt   <= '0;
      rasterCnt <= '0;
      acInvert  <= 1'b0;
    end else begin
      if (chTick) phase <= ~phase;
      if (charAdv) charPos <= lineEnd ? '0 : charPos + POS_W'(1);
      if (frameEnd) begin
        lineCnt   <= '0;
        rasterCnt <= '0;
        acInvert  <= ~acInvert;
      end else if (lineEnd) begin
        lineCnt <= lineCnt + VR_W'(1);
        if (graphicMode || rasterCnt == vpM1) rasterCnt <= '0;
        else rasterCnt <= rasterCnt + VP_W'(1);
      end
    end
  end

  assign inBlank  = charPos >= hnCount;
  assign slotWide = charPos - hnCount;
  assign slot     = slotWide[SLOT_W-1:0];

  assign lineLatch   = inBlank && (slot <= SLOT_W'(1));
  assign chipEnClk   = inBlank && (slot == SLOT_W'(2));
  assign busy        = inBlank && (slot != '0);
  assign frameStrobe = (lineCnt == '0);
  assign rasterAddr  = graphicMode ? '0 : rasterCnt;

  assign ctrl.phase    = phase;
  assign ctrl.rowStep  = rowStep;
  assign ctrl.frameEnd = frameEnd;
  assign ctrl.charPos  = charPos;
endmodule

// File: rtl/lcd_seq_addr.sv
module lcd_seq_addr
  import lcd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [HN_W-1:0]   hnM1,
  input  logic [VR_W-1:0]   vrM1,
  input  logic [VP_W-1:0]   vpM1,
  input  logic              graphicMode,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int PROD_W = ADDR_W + VR_W + 1;

  logic [ADDR_W-1:0] rowBase;
  logic [ADDR_W-1:0] hnWide;
  logic [VR_W:0]     vrCount;
  logic [VP_W:0]     vpCount;
  logic [VR_W:0]     rowsHalf;
  logic [PROD_W-1:0] offsetProd;
  logic [ADDR_W-1:0] halfOffset;
  logic [ADDR_W-1:0] upperAddr;
  logic [ADDR_W-1:0] lowerAddr;

  assign hnWide   = {{(ADDR_W-HN_W){1'b0}}, hnM1} + ADDR_W'(1);
  assign vrCount  = {1'b0, vrM1} + (VR_W+1)'(1);
  assign vpCount  = {1'b0, vpM1} + (VP_W+1)'(1);
  assign rowsHalf = graphicMode ? vrCount
                                : vrCount / {{(VR_W-VP_W){1'b0}}, vpCount};
  assign offsetProd = {{ADDR_W{1'b0}}, rowsHalf} * {{(VR_W+1){1'b0}}, hnWide};
  assign halfOffset = offsetProd[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || ctrl.frameEnd) rowBase <= startAddr;
    else if (ctrl.rowStep)    rowBase <= rowBase + hnWide;
  end

  assign upperAddr = rowBase + {{(ADDR_W-POS_W){1'b0}}, ctrl.charPos};
  assign lowerAddr = upperAddr + halfOffset;
  assign memAddr   = ctrl.phase ? lowerAddr : upperAddr;
endmodule

// File: rtl/lcd_refresh_seq.sv
module lcd_refresh_seq
  import lcd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              chTick,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [HN_W-1:0]   hnM1,
  input  logic [VR_W-1:0]   vrM1,
  input  logic [VP_W-1:0]   vpM1,
  input  logic              graphicMode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [VP_W-1:0]   rasterAddr,
  output logic              charClk,
  output logic              lineLatch,
  output logic              chipEnClk,
  output logic              busy,
  output logic              frameStrobe,
  output logic              acInvert
);
  seqCtrl_t ctrl;

  lcd_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .chTick(chTick), .graphicMode(graphicMode),
    .hnM1(hnM1), .vrM1(vrM1), .vpM1(vpM1), .ctrl(ctrl),
    .rasterAddr(rasterAddr), .lineLatch(lineLatch), .chipEnClk(chipEnClk),
    .busy(busy), .frameStrobe(frameStrobe), .acInvert(acInvert)
  );

  lcd_seq_addr u_addr (
    .clk(clk), .rst(rst), .ctrl(ctrl), .startAddr(startAddr),
    .hnM1(hnM1), .vrM1(vrM1), .vpM1(vpM1), .graphicMode(graphicMode),
    .memAddr(memAddr)
  );

  assign charClk = ctrl.phase;
endmodule

// File: rtl/lcd_refresh_seq_chk.sv
module lcd_refresh_seq_chk
  import lcd_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              chTick,
  input logic              graphicMode,
  input logic [VP_W-1:0]   vpM1,
  input logic [ADDR_W-1:0] memAddr,
  input logic [VP_W-1:0]   rasterAddr,
  input logic              charClk,
  input logic              lineLatch,
  input logic              chipEnClk,
  input logic              busy,
  input logic              frameStrobe,
  input logic              acInvert
);
  assert_phase_flip_R1: assert property (@(posedge clk) disable iff (rst)
    chTick |=> (charClk != $past(charClk)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !chTick |=> ($stable(charClk) && $stable(memAddr)));

  assert_raster_zero_R4: assert property (@(posedge clk) disable iff (rst)
    graphicMode |-> (rasterAddr == '0));

  assert_raster_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !graphicMode |-> (rasterAddr <= vpM1));

  assert_busy_after_latch_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(lineLatch) |-> !busy);

  assert_busy_ends_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !lineLatch);

  assert_ce_window_R7: assert property (@(posedge clk) disable iff (rst)
    chipEnClk |-> (busy && !lineLatch));

  assert_invert_on_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (acInvert != $past(acInvert)) |-> frameStrobe);
endmodule

bind lcd_refresh_seq lcd_refresh_seq_chk u_chk (.*);

// File: tb/sim_lcd_refresh_seq.sv
module sim_lcd_refresh_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chTick = 1'b0;
  logic [15:0] startAddr = 16'h0000;
  logic [6:0]  hnM1 = 7'd3;
  logic [7:0]  vrM1 = 8'd3;
  logic [3:0]  vpM1 = 4'd0;
  logic        graphicMode = 1'b1;
  logic [15:0] memAddr;
  logic [3:0]  rasterAddr;
  logic        charClk, lineLatch, chipEnClk, busy, frameStrobe, acInvert;

  int compared = 0;
  int mismatched = 0;

  int cfgHn, cfgVr, cfgVp;
  bit cfgGraphic;
  bit mPh, mInv;
  int mPos, mLine, mRas;
  logic [15:0] mBase;

  always #4 clk = ~clk;

  lcd_refresh_seq u0 (
    .clk(clk), .rst(rst), .chTick(chTick), .startAddr(startAddr),
    .hnM1(hnM1), .vrM1(vrM1), .vpM1(vpM1), .graphicMode(graphicMode),
    .memAddr(memAddr), .rasterAddr(rasterAddr), .charClk(charClk),
    .lineLatch(lineLatch), .chipEnClk(chipEnClk), .busy(busy),
    .frameStrobe(frameStrobe), .acInvert(acInvert)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] halfOffset();
    int rows;
    rows = cfgGraphic ? cfgVr : cfgVr / cfgVp;
    return 16'(rows * cfgHn);
  endfunction

  task automatic compareAll(string scen);
    logic [15:0] up, expAddr;
    string at;
    up = mBase + 16'(mPos);
    expAddr = mPh ? up + halfOffset() : up;
    if (scen == "R9") at = "R9";
    else if (mPh) at = "R1";
    else if (mPos >= cfgHn) at = "R3";
    else at = "R2";
    chk({at, " memAddr"}, 32'(memAddr), 32'(expAddr));
    chk("R2 charClk", 32'(charClk), 32'(mPh));
    chk(cfgGraphic ? "R4 raster" : "R5 raster", 32'(rasterAddr),
        32'(cfgGraphic ? 0 : mRas));
    chk("R6 busy", 32'(busy), 32'(mPos >= cfgHn + 1 && mPos <= cfgHn + 7));
    chk("R7 lineLatch", 32'(lineLatch), 32'(mPos == cfgHn || mPos == cfgHn + 1));
    chk("R7 chipEnClk", 32'(chipEnClk), 32'(mPos == cfgHn + 2));
    chk("R8 frameStrobe", 32'(frameStrobe), 32'(mLine == 0));
    chk("R8 acInvert", 32'(acInvert), 32'(mInv));
  endtask

  task automatic modelAdvance();
    if (mPos == cfgHn + 7) begin
      mPos = 0;
      if (mLine == cfgVr - 1) begin
        mLine = 0; mRas = 0; mBase = startAddr; mInv = !mInv;
      end else begin
        mLine++;
        if (cfgGraphic) mBase = mBase + 16'(cfgHn);
        else if (mRas == cfgVp - 1) begin mRas = 0; mBase = mBase + 16'(cfgHn); end
        else mRas++;
      end
    end else mPos++;
  endtask

  task automatic step(bit t, string scen);
    chTick = t;
    @(posedge clk);
    if (t) begin
      if (mPh) modelAdvance();
      mPh = !mPh;
    end
    @(negedge clk);
    compareAll(scen);
  endtask

  task automatic configure(int hn, int vr, int vp, bit g, logic [15:0] sa);
    @(negedge clk);
    rst = 1'b1; chTick = 1'b0;
    cfgHn = hn; cfgVr = vr; cfgVp = vp; cfgGraphic = g;
    hnM1 = 7'(hn - 1); vrM1 = 8'(vr - 1); vpM1 = 4'(vp - 1);
    graphicMode = g; startAddr = sa;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mPh = 0; mInv = 0; mPos = 0; mLine = 0; mRas = 0; mBase = sa;
  endtask

  task automatic test_reset();
    configure(4, 4, 1, 1'b1, 16'h1230);
    chk("R10 memAddr", 32'(memAddr), 32'h1230);
    chk("R10 charClk", 32'(charClk), 32'd0);
    chk("R10 raster", 32'(rasterAddr), 32'd0);
    chk("R10 frameStrobe", 32'(frameStrobe), 32'd1);
    chk("R10 acInvert", 32'(acInvert), 32'd0);
    chk("R10 busy", 32'(busy), 32'd0);
  endtask

  task automatic test_graphic();
    configure(4, 4, 1, 1'b1, 16'h1230);
    for (int i = 0; i < 2 * 4 * 12 * 2; i++) step(1'b1, "G");
  endtask

  task automatic test_character();
    configure(2, 6, 3, 1'b0, 16'h0040);
    for (int i = 0; i < 6 * 10 * 2 + 20; i++) step(1'b1, "C");
  endtask

  task automatic test_idle();
    configure(5, 3, 1, 1'b1, 16'h2000);
    for (int i = 0; i < 60; i++) step((i % 3) != 1, "I");
  endtask

  task automatic test_restart();
    configure(3, 2, 1, 1'b1, 16'h0100);
    for (int i = 0; i < 10; i++) step(1'b1, "R9");
    startAddr = 16'h0800;
    while (!(mLine == 0 && mPos == 0 && !mPh && mInv)) step(1'b1, "R9");
    chk("R9 new base at frame start", 32'(memAddr), 32'h0800);
    for (int i = 0; i < 30; i++) step(1'b1, "R9");
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    test_reset();
    test_graphic();
    test_character();
    test_idle();
    test_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule